// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a shared-memory system and keeps the caches of a fixed number of processors coherent for the memory blocks it owns. For every block it holds a sharer vector with one bit per cache and a single dirty flag that marks an exclusive owner. A cache reaches this controller only after a miss or when it gives a dirty line back. The controller consults the block's entry and sends snoop messages only to the caches named there, never to all of them. It then updates the entry and replies to the requester.

Requests and replies travel over a point-to-point interface. The controller handles one transaction at a time, and any request that arrives while a transaction is open is refused at once. The backing store is a small synchronous array of flops inside the block. Snoops go out as a single-cycle pulse carrying a target mask. Caches answer one acknowledgement per cycle, and an owner's acknowledgement carries its copy of the line.

Top module: `dir_coherence_home`

## Requirements
- R1: After reset every directory entry is empty and clean, every memory word reads as zero, and `rsp_valid`, `snp_valid` and `nack_valid` are low.
- R2: A read miss (`req_op` 0) to a clean block sends no snoop. It returns a data reply (`rsp_kind` 0) with the memory word in the second cycle after the request is accepted, and it marks the requester as a sharer.
- R3: A read miss to a dirty block sends exactly one fetch snoop (`snp_kind` 1) to the owner. The data in the owner's acknowledgement is written to memory and sent to the requester, and the block becomes clean with owner and requester both marked as sharers.
- R4: A write miss (`req_op` 1) sends one invalidate snoop (`snp_kind` 0) whose mask holds every sharer except the requester. No reply goes out before each addressed cache has acknowledged. Acknowledgements from caches outside the mask are ignored, and acknowledgement data on a clean block leaves memory unchanged.
- R5: After a write miss completes, the requester is the only sharer and the block is dirty, so the next read miss by another cache fetches from that cache alone.
- R6: A request that arrives while a transaction is open raises `nack_valid` in the same cycle with `nack_dst` equal to its source, and the request is dropped. A request that arrives while no transaction is open is accepted without a NACK.
- R7: A write-back (`req_op` 2) from the dirty owner stores its data in memory, clears the owner's sharer bit and the dirty flag, and gets a write-back reply (`rsp_kind` 1). The next read miss to that block is served from memory without a snoop.
- R8: A write-back from a cache that is not the dirty owner still gets a write-back reply (`rsp_kind` 1), but it changes neither memory nor the directory entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | SRC_W | Requesting cache |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| nack_valid | output | 1 | Request refused, retry later |
| nack_dst | output | SRC_W | Cache whose request was refused |
| rsp_valid | output | 1 | Reply present this cycle |
| rsp_dst | output | SRC_W | Cache receiving the reply |
| rsp_kind | output | 2 | 0 data, 1 write-back done |
| rsp_data | output | DATA_W | Block contents for a data reply |
| snp_valid | output | 1 | Snoop message this cycle |
| snp_mask | output | N_CACHE | Caches addressed by the snoop |
| snp_kind | output | 1 | 0 invalidate, 1 fetch |
| snp_blk | output | BLK_W | Block the snoop concerns |
| cack_valid | input | 1 | Snoop acknowledgement present |
| cack_src | input | SRC_W | Acknowledging cache |
| cack_data | input | DATA_W | Line data from an owner |

## Verification
A wrong sharer vector shows up at the next miss to that block. The snoop mask on that miss is one cycle after acceptance, so it names too many or too few caches. A lost dirty flag shows up the same way: a read that should fetch is served stale from memory. A stale memory word appears in the data reply of a later clean read. A stuck pending mask shows up as a reply that never comes or that overtakes an acknowledgement. The directed scenarios therefore read every block again after each change and compare both the snoop mask and the returned data.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  localparam logic [1:0] OP_RDMISS = 2'd0;
  localparam logic [1:0] OP_WRMISS = 2'd1;
  localparam logic [1:0] OP_WRBACK = 2'd2;

  localparam logic [1:0] RK_DATA   = 2'd0;
  localparam logic [1:0] RK_WBDONE = 2'd1;

  localparam logic SK_INV   = 1'b0;
  localparam logic SK_FETCH = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOOK    = 3'd1,
    ST_WAIT    = 3'd2,
    ST_REFETCH = 3'd3,
    ST_REPLY   = 3'd4
  } eng_state_e;
endpackage

// File: rtl/dirc_dir_store.sv
module dirc_dir_store #(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 16,
  localparam int BLK_W  = $clog2(N_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLK_W-1:0]   idx,
  input  logic               wr_en,
  input  logic [N_CACHE-1:0] wr_pres,
  input  logic               wr_dirty,
  output logic [N_CACHE-1:0] rd_pres,
  output logic               rd_dirty
);
  logic [N_CACHE-1:0] pres_q  [N_BLK];
  logic               dirty_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_entry
    logic hit;
    assign hit = wr_en && (idx == BLK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (hit) begin
        pres_q[b]  <= wr_pres;
        dirty_q[b] <= wr_dirty;
      end
    end
  end

  assign rd_pres  = pres_q[idx];
  assign rd_dirty = dirty_q[idx];
endmodule

// File: rtl/dirc_mem.sv
module dirc_mem #(
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [N_BLK];
  logic [DATA_W-1:0] rd_q;

  for (genvar b = 0; b < N_BLK; b++) begin : g_word
    logic hit;
    assign hit = wr_en && (idx == BLK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[b] <= '0;
      else if (hit) word_q[b] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= word_q[idx];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dirc_engine.sv
module dirc_engine
  import dirc_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 16,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(N_CACHE),
  localparam int BLK_W  = $clog2(N_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [1:0]         req_op,
  input  logic [BLK_W-1:0]   req_blk,
  input  logic [DATA_W-1:0]  req_data,
  input  logic               cack_valid,
  input  logic [SRC_W-1:0]   cack_src,
  input  logic [DATA_W-1:0]  cack_data,
  input  logic [N_CACHE-1:0] ent_pres,
  input  logic               ent_dirty,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [BLK_W-1:0]   cur_blk,
  output logic               ent_we,
  output logic [N_CACHE-1:0] ent_wpres,
  output logic               ent_wdirty,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               nack_valid,
  output logic [SRC_W-1:0]   nack_dst,
  output logic               rsp_valid,
  output logic [SRC_W-1:0]   rsp_dst,
  output logic [1:0]         rsp_kind,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               snp_valid,
  output logic [N_CACHE-1:0] snp_mask,
  output logic               snp_kind,
  output logic [BLK_W-1:0]   snp_blk
);
  eng_state_e         st_q, st_d;
  logic [SRC_W-1:0]   src_q;
  logic [1:0]         op_q;
  logic [BLK_W-1:0]   blk_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [N_CACHE-1:0] pend_q, pend_d;
  logic               accept;
  logic [N_CACHE-1:0] req_oh, ack_oh, others;

  assign req_oh = N_CACHE'(1) << src_q;
  assign ack_oh = N_CACHE'(1) << cack_src;
  assign others = ent_pres & ~req_oh;

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    accept     = 1'b0;
    ent_we     = 1'b0;
    ent_wpres  = ent_pres;
    ent_wdirty = ent_dirty;
    mem_we     = 1'b0;
    mem_wdata  = cack_data;
    snp_valid  = 1'b0;
    snp_mask   = '0;
    snp_kind   = SK_INV;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_d   = ST_LOOK;
        end
      end
      ST_LOOK: begin
        st_d = ST_REPLY;
        if (op_q == OP_RDMISS) begin
          if (ent_dirty) begin
            snp_valid = 1'b1;
            snp_kind  = SK_FETCH;
            snp_mask  = ent_pres;
            pend_d    = ent_pres;
            st_d      = ST_WAIT;
          end else begin
            ent_we    = 1'b1;
            ent_wpres = ent_pres | req_oh;
          end
        end else if (op_q == OP_WRMISS) begin
          if (others == '0) begin
            ent_we     = 1'b1;
            ent_wpres  = req_oh;
            ent_wdirty = 1'b1;
          end else begin
            snp_valid = 1'b1;
            snp_kind  = SK_INV;
            snp_mask  = others;
            pend_d    = others;
            st_d      = ST_WAIT;
          end
        end else if (op_q == OP_WRBACK) begin
          if (ent_dirty && ent_pres[src_q]) begin
            ent_we     = 1'b1;
            ent_wpres  = ent_pres & ~req_oh;
            ent_wdirty = 1'b0;
            mem_we     = 1'b1;
            mem_wdata  = wdata_q;
          end
        end
      end
      ST_WAIT: begin
        if (cack_valid && pend_q[cack_src]) begin
          pend_d = pend_q & ~ack_oh;
          mem_we = ent_dirty;
          if (pend_d == '0) begin
            ent_we = 1'b1;
            st_d   = ST_REFETCH;
            if (op_q == OP_RDMISS) begin
              ent_wpres  = ent_pres | req_oh;
              ent_wdirty = 1'b0;
            end else begin
              ent_wpres  = req_oh;
              ent_wdirty = 1'b1;
            end
          end
        end
      end
      ST_REFETCH: st_d = ST_REPLY;
      ST_REPLY:   st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      op_q    <= '0;
      blk_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      src_q   <= req_src;
      op_q    <= req_op;
      blk_q   <= req_blk;
      wdata_q <= req_data;
    end
  end

  assign cur_blk    = blk_q;
  assign nack_valid = req_valid && (st_q != ST_IDLE);
  assign nack_dst   = req_src;
  assign rsp_valid  = (st_q == ST_REPLY);
  assign rsp_dst    = src_q;
  assign rsp_kind   = (op_q == OP_WRBACK) ? RK_WBDONE : RK_DATA;
  assign rsp_data   = mem_rdata;
  assign snp_blk    = blk_q;
endmodule

// File: rtl/dir_coherence_home.sv
module dir_coherence_home #(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 16,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(N_CACHE),
  localparam int BLK_W  = $clog2(N_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [1:0]         req_op,
  input  logic [BLK_W-1:0]   req_blk,
  input  logic [DATA_W-1:0]  req_data,
  output logic               nack_valid,
  output logic [SRC_W-1:0]   nack_dst,
  output logic               rsp_valid,
  output logic [SRC_W-1:0]   rsp_dst,
  output logic [1:0]         rsp_kind,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               snp_valid,
  output logic [N_CACHE-1:0] snp_mask,
  output logic               snp_kind,
  output logic [BLK_W-1:0]   snp_blk,
  input  logic               cack_valid,
  input  logic [SRC_W-1:0]   cack_src,
  input  logic [DATA_W-1:0]  cack_data
);
  logic [BLK_W-1:0]   cur_blk;
  logic               ent_we, ent_wdirty, ent_dirty;
  logic [N_CACHE-1:0] ent_wpres, ent_pres;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wdata, mem_rdata;

  dirc_dir_store #(.N_CACHE(N_CACHE), .N_BLK(N_BLK)) u_dir (
    .clk(clk), .rst_n(rst_n), .idx(cur_blk), .wr_en(ent_we),
    .wr_pres(ent_wpres), .wr_dirty(ent_wdirty),
    .rd_pres(ent_pres), .rd_dirty(ent_dirty)
  );

  dirc_mem #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .idx(cur_blk), .wr_en(mem_we),
    .wr_data(mem_wdata), .rd_data(mem_rdata)
  );

  dirc_engine #(.N_CACHE(N_CACHE), .N_BLK(N_BLK), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_src(req_src), .req_op(req_op),
    .req_blk(req_blk), .req_data(req_data),
    .cack_valid(cack_valid), .cack_src(cack_src), .cack_data(cack_data),
    .ent_pres(ent_pres), .ent_dirty(ent_dirty), .mem_rdata(mem_rdata),
    .cur_blk(cur_blk), .ent_we(ent_we), .ent_wpres(ent_wpres),
    .ent_wdirty(ent_wdirty), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .nack_valid(nack_valid), .nack_dst(nack_dst),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_kind(snp_kind),
    .snp_blk(snp_blk)
  );
endmodule

// File: rtl/dirc_checker.sv
module dirc_checker #(
  parameter int N_CACHE = 4,
  parameter int SRC_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               nack_valid,
  input logic               rsp_valid,
  input logic               snp_valid,
  input logic [N_CACHE-1:0] snp_mask,
  input logic               snp_kind,
  input logic               cack_valid,
  input logic [SRC_W-1:0]   cack_src
);
  logic               open_q;
  logic [N_CACHE-1:0] owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        open_q <= 1'b0;
    else if (req_valid && !nack_valid) open_q <= 1'b1;
    else if (rsp_valid)                open_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          owed_q <= '0;
    else if (snp_valid)  owed_q <= snp_mask;
    else if (cack_valid) owed_q <= owed_q & ~(N_CACHE'(1) << cack_src);
  end

  assert_rsp_inside_txn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> open_q);
  assert_fetch_one_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_kind) |-> ($countones(snp_mask) == 1));
  assert_snoop_has_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (snp_mask != '0));
  assert_reply_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (owed_q == '0));
  assert_nack_when_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && open_q) |-> nack_valid);
  assert_accept_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !open_q) |-> !nack_valid);
endmodule

bind dir_coherence_home dirc_checker #(.N_CACHE(N_CACHE), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .nack_valid(nack_valid),
  .rsp_valid(rsp_valid), .snp_valid(snp_valid), .snp_mask(snp_mask),
  .snp_kind(snp_kind), .cack_valid(cack_valid), .cack_src(cack_src)
);

// File: tb/dir_coherence_home_tb.sv
`timescale 1ns/1ps
module dir_coherence_home_tb;
  localparam int NC = 4;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int SW = $clog2(NC);
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [1:0] req_op = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic cack_valid = 1'b0;
  logic [SW-1:0] cack_src = '0;
  logic [DW-1:0] cack_data = '0;
  logic nack_valid, rsp_valid, snp_valid, snp_kind;
  logic [SW-1:0] nack_dst, rsp_dst;
  logic [1:0] rsp_kind;
  logic [DW-1:0] rsp_data;
  logic [NC-1:0] snp_mask;
  logic [BW-1:0] snp_blk;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic s_valid, s_kind;
  logic [NC-1:0] s_mask;
  logic [BW-1:0] s_blk;
  logic r_got;
  int r_lat;
  logic [1:0] r_kind;
  logic [SW-1:0] r_dst;
  logic [DW-1:0] r_data;

  always #2 clk = ~clk;

  dir_coherence_home u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_op(req_op), .req_blk(req_blk), .req_data(req_data),
    .nack_valid(nack_valid), .nack_dst(nack_dst), .rsp_valid(rsp_valid),
    .rsp_dst(rsp_dst), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_kind(snp_kind),
    .snp_blk(snp_blk), .cack_valid(cack_valid), .cack_src(cack_src),
    .cack_data(cack_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // request accepted at the next edge; returns at the negedge of the lookup cycle
  task automatic send(input int src, input logic [1:0] op, input int blk, input logic [DW-1:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_src = SW'(src); req_op = op; req_blk = BW'(blk); req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    s_valid = snp_valid; s_kind = snp_kind; s_mask = snp_mask; s_blk = snp_blk;
  endtask

  task automatic ack(input int src, input logic [DW-1:0] data);
    @(negedge clk);
    cack_valid = 1'b1; cack_src = SW'(src); cack_data = data;
    @(negedge clk);
    cack_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    r_got = 1'b0; r_lat = 0;
    for (int i = 1; i <= 30 && !r_got; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        r_got = 1'b1; r_lat = i; r_kind = rsp_kind; r_dst = rsp_dst; r_data = rsp_data;
      end
    end
  endtask

  task automatic expect_data(input string tag, input int dst, input logic [DW-1:0] data);
    wait_rsp();
    chk(r_got, {tag, " reply seen"}, DW'(r_got), 1);
    chk(r_kind == 2'd0 && r_dst == SW'(dst), {tag, " reply kind/dst"}, DW'({r_kind, r_dst}), DW'({2'd0, SW'(dst)}));
    chk(r_data == data, {tag, " reply data"}, r_data, data);
  endtask

  task automatic t_reset_R1();
    chk(!rsp_valid && !snp_valid && !nack_valid, "R1 quiet after reset", DW'({rsp_valid, snp_valid, nack_valid}), 0);
  endtask

  task automatic t_clean_read_R2();
    send(0, 2'd0, 3, '0);
    chk(!s_valid, "R2 clean read no snoop", DW'(s_valid), 0);
    wait_rsp();
    chk(r_got && r_lat == 1, "R2 reply two cycles after accept", DW'(r_lat), 1);
    chk(r_data == '0 && r_kind == 2'd0, "R1 memory reads zero", r_data, 0);
  endtask

  task automatic t_write_single_R4();
    send(1, 2'd1, 3, '0);
    chk(s_valid && s_kind == 1'b0 && s_mask == 4'b0001 && s_blk == 4'd3, "R4 invalidate sharer 0",
        DW'({s_valid, s_kind, s_mask, s_blk}), DW'({1'b1, 1'b0, 4'b0001, 4'd3}));
    ack(0, 32'h0);
    expect_data("R4 write miss", 1, 32'h0);
  endtask

  task automatic t_read_dirty_R3();
    send(2, 2'd0, 3, '0);
    chk(s_valid && s_kind == 1'b1 && s_mask == 4'b0010, "R3 fetch from owner 1",
        DW'({s_valid, s_kind, s_mask}), DW'({1'b1, 1'b1, 4'b0010}));
    ack(1, 32'hA5A5_0001);
    expect_data("R3 fetched", 2, 32'hA5A5_0001);
    send(3, 2'd0, 3, '0);
    chk(!s_valid, "R3 block clean after fetch", DW'(s_valid), 0);
    expect_data("R3 memory updated", 3, 32'hA5A5_0001);
  endtask

  task automatic t_multi_inval_R4();
    send(0, 2'd1, 3, '0);
    chk(s_valid && s_kind == 1'b0 && s_mask == 4'b1110, "R4 invalidate all sharers",
        DW'({s_valid, s_mask}), DW'({1'b1, 4'b1110}));
    ack(1, 32'hFFFF_FFFF);
    chk(!rsp_valid, "R4 no reply after 1 of 3 acks", DW'(rsp_valid), 0);
    ack(2, 32'hFFFF_FFFF);
    chk(!rsp_valid, "R4 no reply after 2 of 3 acks", DW'(rsp_valid), 0);
    ack(0, 32'hFFFF_FFFF);
    chk(!rsp_valid, "R4 stray ack ignored", DW'(rsp_valid), 0);
    ack(3, 32'hFFFF_FFFF);
    expect_data("R4 clean acks keep memory", 0, 32'hA5A5_0001);
  endtask

  task automatic t_nack_R6();
    send(1, 2'd0, 3, '0);
    chk(s_valid && s_kind == 1'b1 && s_mask == 4'b0001, "R5 fetch only from writer 0",
        DW'({s_valid, s_kind, s_mask}), DW'({1'b1, 1'b1, 4'b0001}));
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd2; req_op = 2'd0; req_blk = 4'd9;
    #1;
    chk(nack_valid && nack_dst == 2'd2, "R6 busy request refused", DW'({nack_valid, nack_dst}), DW'({1'b1, 2'd2}));
    @(negedge clk);
    req_valid = 1'b0;
    ack(0, 32'h0BAD_CAFE);
    expect_data("R6 open transaction completes", 1, 32'h0BAD_CAFE);
    send(2, 2'd0, 9, '0);
    chk(!s_valid, "R6 refused request left no trace", DW'(s_valid), 0);
    expect_data("R6 later request accepted", 2, 32'h0);
  endtask

  task automatic t_writeback_R7();
    send(0, 2'd1, 5, '0);
    chk(!s_valid, "R4 write miss with no sharers", DW'(s_valid), 0);
    expect_data("R4 write miss uncached", 0, 32'h0);
    send(0, 2'd2, 5, 32'h1234_5678);
    wait_rsp();
    chk(r_got && r_kind == 2'd1 && r_dst == 2'd0, "R7 write-back reply", DW'({r_got, r_kind}), DW'({1'b1, 2'd1}));
    send(2, 2'd0, 5, '0);
    chk(!s_valid, "R7 no snoop after write-back", DW'(s_valid), 0);
    expect_data("R7 memory holds write-back", 2, 32'h1234_5678);
  endtask

  task automatic t_stray_wb_R8();
    send(3, 2'd2, 5, 32'hDEAD_BEEF);
    wait_rsp();
    chk(r_got && r_kind == 2'd1 && r_dst == 2'd3, "R8 non-owner write-back reply", DW'({r_got, r_kind}), DW'({1'b1, 2'd1}));
    send(1, 2'd0, 5, '0);
    chk(!s_valid, "R8 directory unchanged", DW'(s_valid), 0);
    expect_data("R8 memory unchanged", 1, 32'h1234_5678);
  endtask

  task automatic t_upgrade_R5();
    send(2, 2'd1, 5, '0);
    chk(s_valid && s_kind == 1'b0 && s_mask == 4'b0010, "R4 requester left out of mask",
        DW'({s_valid, s_mask}), DW'({1'b1, 4'b0010}));
    ack(1, 32'h0);
    expect_data("R5 upgrade", 2, 32'h1234_5678);
    send(3, 2'd0, 5, '0);
    chk(s_valid && s_kind == 1'b1 && s_mask == 4'b0100, "R5 sole owner fetched",
        DW'({s_valid, s_kind, s_mask}), DW'({1'b1, 1'b1, 4'b0100}));
    ack(2, 32'h0000_0055);
    expect_data("R5 owner data", 3, 32'h0000_0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_clean_read_R2();
    t_write_single_R4();
    t_read_dirty_R3();
    t_multi_inval_R4();
    t_nack_R6();
    t_writeback_R7();
    t_stray_wb_R8();
    t_upgrade_R5();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule